// File: doc/BRIEF.md
# Read-Sequence Command Detector

This block watches the read traffic of an asynchronous SRAM-style bus. A read is in progress while chip enable and output enable are both low. The read finishes when either of those strobes rises, and the address is taken at that point. When six such reads arrive back to back, their addresses match a fixed ordered list, and no write arrives in between, the block accepts a non-volatile command. The last address of the six chooses the command: STORE (copy to the non-volatile array) or RECALL (copy back).

After a command is accepted, the block runs two phases timed by a microsecond tick: a processing phase and then an operation phase whose length depends on the command. The command pulse is issued when the processing phase ends. The I/O lockout output stays high from acceptance to the end of the operation phase, and no reads are matched during that time. The bus signals arrive already synchronised to the block clock.

Top module: `nvcmd_seq_detect`

## Requirements
- R1: After the synchronous active-high reset, and whenever reset is applied mid-operation, `io_lock`, `store_go` and `recall_go` are low on the next cycle, and no command from before the reset takes effect.
- R2: Reads of PFX0, PFX1, PFX2, PFX3, PFX4 and then STORE_ADDR, in that order, accept a STORE command, and `store_go` pulses for exactly one cycle.
- R3: The same five prefix reads followed by RECALL_ADDR accept a RECALL command, and `recall_go` pulses for exactly one cycle. `store_go` and `recall_go` are never high together.
- R4: A read whose address is not the next expected one returns the matcher to its start, so an out-of-order sequence produces no command.
- R5: A mismatching read whose address equals PFX0 counts as the first step of a new sequence.
- R6: Any cycle with chip enable low and write enable low discards a partial sequence. This includes a write enable that drops during a read, and that read is not counted.
- R7: A read is counted when it ends on a rising chip enable or on a rising output enable. Its address is the one present in its last active cycle.
- R8: `io_lock` rises on the cycle after the sixth read is accepted. The command pulse comes on the cycle after the SS_US-th tick seen while `io_lock` is high.
- R9: `io_lock` falls after a total of SS_US + STORE_US ticks for STORE, or SS_US + RECALL_US ticks for RECALL, counted while it is high.
- R10: Reads that finish while `io_lock` is high are ignored, and no partial progress made during lockout survives the end of lockout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_n | input | 1 | Chip enable, active low, synchronised view |
| oe_n | input | 1 | Output enable, active low, synchronised view |
| we_n | input | 1 | Write enable, active low, synchronised view |
| addr | input | AW | Bus address |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| store_go | output | 1 | One-cycle STORE start pulse |
| recall_go | output | 1 | One-cycle RECALL start pulse |
| io_lock | output | 1 | High while a command is processing or running |

## Verification
The bench builds the block with SS_US = 6, STORE_US = 4 and RECALL_US = 5, and with a tick every fourth clock, keeping the default addresses. These short windows let the bench count every processing and operation tick exactly in a few dozen cycles. They also let a complete six-read sequence be issued while a STORE lockout is still running, so the ignore rule is checked against a real attempt to trigger a command. The long default durations use the same counter, only wider.

// File: rtl/nvcmd_pkg.sv
package nvcmd_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PROC = 2'd1,
        PH_OPER = 2'd2
    } phase_e;

    typedef enum logic {
        OP_STORE  = 1'b0,
        OP_RECALL = 1'b1
    } op_e;

    localparam int unsigned SEQ_LEN   = 6;
    localparam int unsigned STEP_W    = 3;

endpackage

// File: rtl/nvcmd_strobe_sampler.sv
module nvcmd_strobe_sampler #(
    parameter int unsigned AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    output logic          rd_done,
    output logic [AW-1:0] rd_addr,
    output logic          wr_abort
);

    typedef struct packed {
        logic          act;
        logic          bad;
        logic [AW-1:0] addr;
    } samp_s;

    samp_s s_d, s_q;
    logic  act_now;

    always_comb begin
        act_now  = !ce_n && !oe_n;
        wr_abort = !ce_n && !we_n;
        rd_done  = s_q.act && !act_now && !s_q.bad;
        rd_addr  = s_q.addr;

        s_d      = s_q;
        s_d.act  = act_now;
        if (act_now) begin
            s_d.addr = addr;
            s_d.bad  = (s_q.act ? s_q.bad : 1'b0) | !we_n;
        end else begin
            s_d.bad  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R7: a read completes in a single cycle and needs a new active phase
    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        rd_done |=> !rd_done);

endmodule

// File: rtl/nvcmd_seq_matcher.sv
module nvcmd_seq_matcher
    import nvcmd_pkg::*;
#(
    parameter int unsigned    AW          = 16,
    parameter logic [AW-1:0]  PFX0        = 16'h4E38,
    parameter logic [AW-1:0]  PFX1        = 16'hB1C7,
    parameter logic [AW-1:0]  PFX2        = 16'h83E0,
    parameter logic [AW-1:0]  PFX3        = 16'h7C1F,
    parameter logic [AW-1:0]  PFX4        = 16'h703F,
    parameter logic [AW-1:0]  STORE_ADDR  = 16'h8FC0,
    parameter logic [AW-1:0]  RECALL_ADDR = 16'h4C63
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          lock,
    input  logic          rd_done,
    input  logic [AW-1:0] rd_addr,
    input  logic          wr_abort,
    output logic          cmd_valid,
    output op_e           cmd_op
);

    localparam int unsigned NPFX = SEQ_LEN - 1;
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NPFX);

    typedef struct packed {
        logic [STEP_W-1:0] step;
    } match_s;

    match_s m_d, m_q;
    logic [(1<<STEP_W)-1:0] pfx_hit;
    logic                   hit_store;
    logic                   hit_recall;

    function automatic logic [AW-1:0] pfx_at(input int unsigned idx);
        case (idx)
            0:       pfx_at = PFX0;
            1:       pfx_at = PFX1;
            2:       pfx_at = PFX2;
            3:       pfx_at = PFX3;
            default: pfx_at = PFX4;
        endcase
    endfunction

    for (genvar i = 0; i < (1 << STEP_W); i++) begin : g_pfx
        if (i < NPFX) begin : g_cmp
            assign pfx_hit[i] = (rd_addr == pfx_at(i));
        end else begin : g_none
            assign pfx_hit[i] = 1'b0;
        end
    end

    assign hit_store  = (rd_addr == STORE_ADDR);
    assign hit_recall = (rd_addr == RECALL_ADDR);

    always_comb begin
        m_d       = m_q;
        cmd_valid = 1'b0;
        cmd_op    = OP_STORE;
        if (lock || wr_abort) begin
            m_d.step = '0;
        end else if (rd_done) begin
            if (m_q.step == LAST_STEP) begin
                if (hit_store) begin
                    cmd_valid = 1'b1;
                    cmd_op    = OP_STORE;
                    m_d.step  = '0;
                end else if (hit_recall) begin
                    cmd_valid = 1'b1;
                    cmd_op    = OP_RECALL;
                    m_d.step  = '0;
                end else begin
                    m_d.step  = pfx_hit[0] ? STEP_W'(1) : '0;
                end
            end else if (pfx_hit[m_q.step]) begin
                m_d.step = m_q.step + STEP_W'(1);
            end else begin
                m_d.step = pfx_hit[0] ? STEP_W'(1) : '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            m_q <= '0;
        end else begin
            m_q <= m_d;
        end
    end

    // R10: lockout holds the matcher at its start
    p_lock_idle_r10: assert property (@(posedge clk) disable iff (rst)
        lock |=> (m_q.step == '0));

    // R6: a write clears progress
    p_abort_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_abort && !lock) |=> (m_q.step == '0));

    // R4: progress never passes the final step
    p_step_bound_r4: assert property (@(posedge clk) disable iff (rst)
        m_q.step <= LAST_STEP);

    // R4: progress advances by at most one step per cycle
    p_step_climb_r4: assert property (@(posedge clk) disable iff (rst)
        (m_q.step != $past(m_q.step)) |-> (m_q.step == '0 || m_q.step == STEP_W'(1)
            || m_q.step == $past(m_q.step) + STEP_W'(1)));

endmodule

// File: rtl/nvcmd_phase_timer.sv
module nvcmd_phase_timer
    import nvcmd_pkg::*;
#(
    parameter int unsigned SS_US     = 100,
    parameter int unsigned STORE_US  = 8000,
    parameter int unsigned RECALL_US = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic us_tick,
    input  logic cmd_valid,
    input  op_e  cmd_op,
    output logic store_go,
    output logic recall_go,
    output logic lock
);

    localparam int unsigned MAX_A  = (SS_US > STORE_US) ? SS_US : STORE_US;
    localparam int unsigned MAX_US = (MAX_A > RECALL_US) ? MAX_A : RECALL_US;
    localparam int unsigned CW     = $clog2(MAX_US + 1);
    localparam logic [CW-1:0] SS_LAST     = CW'(SS_US - 1);
    localparam logic [CW-1:0] STORE_LAST  = CW'(STORE_US - 1);
    localparam logic [CW-1:0] RECALL_LAST = CW'(RECALL_US - 1);

    typedef struct packed {
        phase_e        ph;
        op_e           op;
        logic [CW-1:0] cnt;
        logic          sgo;
        logic          rgo;
    } tmr_s;

    tmr_s t_d, t_q;
    logic [CW-1:0] oper_last;

    always_comb begin
        oper_last = (t_q.op == OP_STORE) ? STORE_LAST : RECALL_LAST;
        t_d       = t_q;
        t_d.sgo   = 1'b0;
        t_d.rgo   = 1'b0;
        case (t_q.ph)
            PH_IDLE: begin
                if (cmd_valid) begin
                    t_d.ph  = PH_PROC;
                    t_d.op  = cmd_op;
                    t_d.cnt = '0;
                end
            end
            PH_PROC: begin
                if (us_tick) begin
                    if (t_q.cnt == SS_LAST) begin
                        t_d.ph  = PH_OPER;
                        t_d.cnt = '0;
                        t_d.sgo = (t_q.op == OP_STORE);
                        t_d.rgo = (t_q.op == OP_RECALL);
                    end else begin
                        t_d.cnt = t_q.cnt + CW'(1);
                    end
                end
            end
            PH_OPER: begin
                if (us_tick) begin
                    if (t_q.cnt == oper_last) begin
                        t_d.ph  = PH_IDLE;
                        t_d.cnt = '0;
                    end else begin
                        t_d.cnt = t_q.cnt + CW'(1);
                    end
                end
            end
            default: begin
                t_d.ph  = PH_IDLE;
                t_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign store_go  = t_q.sgo;
    assign recall_go = t_q.rgo;
    assign lock      = (t_q.ph != PH_IDLE);

    // R8: a command pulse only follows the processing phase
    p_go_after_proc_r8: assert property (@(posedge clk) disable iff (rst)
        (store_go || recall_go) |-> ($past(t_q.ph) == PH_PROC));

    // R3: the two command pulses are exclusive
    p_go_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({store_go, recall_go}));

    // R2: a command pulse lasts one cycle
    p_go_single_r2: assert property (@(posedge clk) disable iff (rst)
        (store_go || recall_go) |=> !(store_go || recall_go));

    // R9: lockout is held while a pulse is out
    p_lock_at_go_r9: assert property (@(posedge clk) disable iff (rst)
        (store_go || recall_go) |-> lock);

    // R9: the phase counter stays inside its window
    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (rst)
        (t_q.ph == PH_PROC) |-> (t_q.cnt <= SS_LAST));

endmodule

// File: rtl/nvcmd_seq_detect.sv
module nvcmd_seq_detect
    import nvcmd_pkg::*;
#(
    parameter int unsigned    AW          = 16,
    parameter logic [AW-1:0]  PFX0        = 16'h4E38,
    parameter logic [AW-1:0]  PFX1        = 16'hB1C7,
    parameter logic [AW-1:0]  PFX2        = 16'h83E0,
    parameter logic [AW-1:0]  PFX3        = 16'h7C1F,
    parameter logic [AW-1:0]  PFX4        = 16'h703F,
    parameter logic [AW-1:0]  STORE_ADDR  = 16'h8FC0,
    parameter logic [AW-1:0]  RECALL_ADDR = 16'h4C63,
    parameter int unsigned    SS_US       = 100,
    parameter int unsigned    STORE_US    = 8000,
    parameter int unsigned    RECALL_US   = 200
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic          us_tick,
    output logic          store_go,
    output logic          recall_go,
    output logic          io_lock
);

    logic          rd_done;
    logic [AW-1:0] rd_addr;
    logic          wr_abort;
    logic          cmd_valid;
    op_e           cmd_op;

    nvcmd_strobe_sampler #(.AW(AW)) u_samp (
        .clk      (clk),
        .rst      (rst),
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .we_n     (we_n),
        .addr     (addr),
        .rd_done  (rd_done),
        .rd_addr  (rd_addr),
        .wr_abort (wr_abort)
    );

    nvcmd_seq_matcher #(
        .AW          (AW),
        .PFX0        (PFX0),
        .PFX1        (PFX1),
        .PFX2        (PFX2),
        .PFX3        (PFX3),
        .PFX4        (PFX4),
        .STORE_ADDR  (STORE_ADDR),
        .RECALL_ADDR (RECALL_ADDR)
    ) u_match (
        .clk       (clk),
        .rst       (rst),
        .lock      (io_lock),
        .rd_done   (rd_done),
        .rd_addr   (rd_addr),
        .wr_abort  (wr_abort),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op)
    );

    nvcmd_phase_timer #(
        .SS_US     (SS_US),
        .STORE_US  (STORE_US),
        .RECALL_US (RECALL_US)
    ) u_tmr (
        .clk       (clk),
        .rst       (rst),
        .us_tick   (us_tick),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .store_go  (store_go),
        .recall_go (recall_go),
        .lock      (io_lock)
    );

    // R8: acceptance raises lockout on the following cycle
    p_accept_locks_r8: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> io_lock);

    // R1: reset leaves the outputs quiet
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (!io_lock && !store_go && !recall_go));

endmodule

// File: tb/sim_nvcmd_seq_detect.sv
module sim_nvcmd_seq_detect;

    localparam int CLK_PERIOD = 10;
    localparam int SS         = 6;
    localparam int ST         = 4;
    localparam int RC         = 5;
    localparam logic [15:0] A0 = 16'h4E38, A1 = 16'hB1C7, A2 = 16'h83E0,
                            A3 = 16'h7C1F, A4 = 16'h703F,
                            AS = 16'h8FC0, AR = 16'h4C63;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [15:0] addr = '0;
    logic us_tick;
    logic store_go, recall_go, io_lock;
    logic [1:0] tdiv = '0;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int st_cnt = 0, rc_cnt = 0, lk_ticks = 0, pre_ticks = 0;
    logic go_seen = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) tdiv <= tdiv + 2'd1;
    assign us_tick = (tdiv == 2'd0);

    nvcmd_seq_detect #(.SS_US(SS), .STORE_US(ST), .RECALL_US(RC)) u0 (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .us_tick(us_tick),
        .store_go(store_go), .recall_go(recall_go), .io_lock(io_lock)
    );

    // Monitor at the falling edge
    always @(negedge clk) begin
        if (store_go) st_cnt++;
        if (recall_go) rc_cnt++;
        if (store_go || recall_go) go_seen = 1'b1;
        if (io_lock && us_tick) begin
            lk_ticks++;
            if (!go_seen) pre_ticks++;
        end
        if (!io_lock) go_seen = 1'b0;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: act=%0d exp=<50000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic do_read(input logic [15:0] a, input bit end_oe, input bit we_low);
        @(negedge clk); addr = a; ce_n = 0; oe_n = 0; we_n = ~we_low;
        @(negedge clk);
        @(negedge clk); if (end_oe) oe_n = 1; else ce_n = 1;
        @(negedge clk); ce_n = 1; oe_n = 1; we_n = 1;
    endtask

    task automatic do_write(input logic [15:0] a);
        @(negedge clk); addr = a; ce_n = 0; we_n = 0;
        @(negedge clk); ce_n = 1; we_n = 1;
    endtask

    task automatic prefix(input bit end_oe);
        do_read(A0, end_oe, 0); do_read(A1, end_oe, 0); do_read(A2, end_oe, 0);
        do_read(A3, end_oe, 0); do_read(A4, end_oe, 0);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (!io_lock) break;
        end
    endtask

    task automatic expect_quiet(input string tag, input int s0, input int r0);
        repeat (12) @(negedge clk);
        check(!io_lock && st_cnt == s0 && rc_cnt == r0, tag, st_cnt + rc_cnt, s0 + r0);
    endtask

    task automatic t_reset();
        check(!io_lock, "R1 lock after reset", io_lock, 0);
        check(!store_go && !recall_go, "R1 pulses after reset", store_go, 0);
    endtask

    task automatic t_store();
        int s0 = st_cnt, r0 = rc_cnt, l0, p0;
        prefix(0);
        do_read(AS, 0, 0);
        l0 = lk_ticks; p0 = pre_ticks;
        check(io_lock, "R8 lock rises after store accept", io_lock, 1);
        wait_idle();
        check(st_cnt == s0 + 1, "R2 one store pulse", st_cnt - s0, 1);
        check(rc_cnt == r0, "R3 no recall on store", rc_cnt - r0, 0);
        check(pre_ticks - p0 == SS, "R8 processing ticks", pre_ticks - p0, SS);
        check(lk_ticks - l0 == SS + ST, "R9 store lock ticks", lk_ticks - l0, SS + ST);
    endtask

    task automatic t_recall_oe();
        int s0 = st_cnt, r0 = rc_cnt, l0;
        prefix(1);
        do_read(AR, 1, 0);
        l0 = lk_ticks;
        check(io_lock, "R7 oe-ended reads accepted", io_lock, 1);
        wait_idle();
        check(rc_cnt == r0 + 1, "R3 one recall pulse", rc_cnt - r0, 1);
        check(st_cnt == s0, "R3 no store on recall", st_cnt - s0, 0);
        check(lk_ticks - l0 == SS + RC, "R9 recall lock ticks", lk_ticks - l0, SS + RC);
    endtask

    task automatic t_mismatch();
        int s0 = st_cnt, r0 = rc_cnt;
        do_read(A0, 0, 0); do_read(A2, 0, 0); do_read(A1, 0, 0);
        do_read(A3, 0, 0); do_read(A4, 0, 0); do_read(AS, 0, 0);
        expect_quiet("R4 out-of-order gives nothing", s0, r0);
    endtask

    task automatic t_restart();
        int s0 = st_cnt;
        do_read(A0, 0, 0); do_read(A1, 0, 0); do_read(A0, 0, 0);
        do_read(A1, 0, 0); do_read(A2, 0, 0); do_read(A3, 0, 0);
        do_read(A4, 0, 0); do_read(AS, 0, 0);
        check(io_lock, "R5 PFX0 restarts sequence", io_lock, 1);
        wait_idle();
        check(st_cnt == s0 + 1, "R5 store after restart", st_cnt - s0, 1);
    endtask

    task automatic t_write_abort();
        int s0 = st_cnt, r0 = rc_cnt;
        do_read(A0, 0, 0); do_read(A1, 0, 0); do_read(A2, 0, 0);
        do_write(16'h0001);
        do_read(A3, 0, 0); do_read(A4, 0, 0); do_read(AS, 0, 0);
        expect_quiet("R6 write discards sequence", s0, r0);
        do_read(A0, 0, 0); do_read(A1, 0, 0); do_read(A2, 0, 0);
        do_read(A3, 0, 1);
        do_read(A4, 0, 0); do_read(AR, 0, 0);
        expect_quiet("R6 we low during read aborts", s0, r0);
    endtask

    task automatic t_locked();
        int s0 = st_cnt, r0 = rc_cnt;
        prefix(0);
        do_read(AS, 0, 0);
        prefix(0);
        do_read(AR, 0, 0);
        check(io_lock, "R10 still locked after reads", io_lock, 1);
        prefix(0);
        wait_idle();
        do_read(AR, 0, 0);
        expect_quiet("R10 locked reads ignored", s0 + 1, r0);
    endtask

    task automatic t_reset_mid();
        int s0 = st_cnt;
        prefix(0);
        do_read(AS, 0, 0);
        repeat (3) @(negedge clk);
        rst = 1;
        @(negedge clk);
        check(!io_lock, "R1 reset mid-operation clears lock", io_lock, 0);
        rst = 0;
        repeat (60) @(negedge clk);
        check(st_cnt == s0, "R1 no pulse after reset", st_cnt - s0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_store();
        t_recall_oe();
        t_mismatch();
        t_restart();
        t_write_abort();
        t_locked();
        t_reset_mid();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule